// File: doc/BRIEF.md
# Lockable Register-Page Protection Controller

This block sits between a write-buffer front end and the storage of a small secure memory. The storage is a 128-byte data array (four 32-byte pages at 00h–7Fh), an 8-byte secret at 80h–87h and an 8-byte register page at 88h–8Fh. The block holds all three. The front end presents an 8-byte commit (an address and eight data bytes). The block works out, per byte, whether the write is allowed and what value lands. It updates its storage and reports the effective bytes with one enable per lane.

Protection comes from codes held in the register page. A function byte holding AAh or 55h switches on its function and can no longer be rewritten. Any other value does neither. The four function bytes are: 88h (secret lock), 89h (lock of all four data pages), 8Ah (bit-clear-only mode on page 1) and 8Bh (page-0 lock). Reads are answered combinationally. The secret never appears on the read port and is offered only on a dedicated port for a hash engine. Addresses 90h–97h return a 64-bit device identity image.

Top module: `wg_guard`

## Requirements
- R1: After a synchronous reset every stored byte (data, secret, register page) reads as FFh, no protection function is active, and wr_valid, wr_en and wr_data are zero.
- R2: Function bytes 88h–8Bh take any value while they hold neither AAh nor 55h. Once one holds AAh or 55h, a later commit leaves it unchanged (its lane enable is 0) and its function is active.
- R3: While 89h holds AAh/55h, no byte in 00h–7Fh is written. This overrides both the page-0 lock and bit-clear-only mode.
- R4: While 8Bh holds AAh/55h, bytes 00h–1Fh are not written, and pages 1–3 remain writable.
- R5: While 8Ah holds AAh/55h (and 89h does not), a write to 20h–3Fh stores old AND new. Other pages store the new value unchanged.
- R6: Secret bytes 80h–87h are written unless 88h holds AAh/55h. A read of 80h–87h always returns FFh. secret_key carries the stored secret, with the byte at 80h in bits 7:0.
- R7: When factory_tag is AAh, 8Eh/8Fh read maker_id (low byte at 8Eh) and are not written. For any other factory_tag they are plain stored user bytes. 8Ch/8Dh are always plain user bytes that never lock.
- R8: A read of 90h+k (k = 0..7) returns dev_id bits 8k+7:8k, with the family code in bits 7:0. A commit at 90h or above writes nothing. A read at 98h or above returns FFh.
- R9: Bits 2:0 of cmt_addr are ignored, and lane i addresses base+i, carried in wr_data bits 8i+7:8i. On the edge after cmt_valid, wr_valid is 1, wr_en shows the allowed lanes and wr_data holds the stored values, with 00h on disabled lanes. A read in the next cycle shows the new contents. Without a commit, wr_valid, wr_en and wr_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmt_valid | input | 1 | Commit request strobe |
| cmt_addr | input | 8 | Commit address (8-byte aligned internally) |
| cmt_data | input | 64 | Eight commit bytes, lane i in bits 8i+7:8i |
| factory_tag | input | 8 | Factory code; AAh locks 8Eh/8Fh to maker_id |
| maker_id | input | 16 | Maker identifier served at 8Eh/8Fh when locked |
| dev_id | input | 64 | Device identity image served at 90h–97h |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| wr_valid | output | 1 | Commit result valid |
| wr_en | output | 8 | Per-lane write enable of the last commit |
| wr_data | output | 64 | Effective bytes of the last commit |
| secret_key | output | 64 | Stored secret for the hash engine only |

## Verification
The bench targets several corner cases.

- A commit that rewrites a function byte already holding a code must be refused. A design that checked the new value instead of the stored one would unlock itself.
- Bit-clear-only mode must AND with the old byte and stay off outside page 1. A design that got this wrong would set bits back to 1 or would corrupt page 0 or page 2.
- The all-page lock must win over page-1 mode. If it did not, page 1 would still change under a full lock.
- Secret reads must return FFh, and the maker bytes must follow factory_tag. Getting either wrong leaks the key or lets the factory identifier be overwritten.
- Commits at and beyond the identity window must produce all-zero enables.

// File: rtl/wg_pkg.sv
package wg_pkg;

    localparam int LANES        = 8;
    localparam int PAGE_BYTES   = 32;
    localparam int PAGE_SHIFT   = $clog2(PAGE_BYTES);
    localparam int DATA_BYTES   = 4 * PAGE_BYTES;
    localparam int SECRET_BASE  = DATA_BYTES;
    localparam int SECRET_BYTES = 8;
    localparam int REG_BASE     = SECRET_BASE + SECRET_BYTES;
    localparam int REG_BYTES    = 8;
    localparam int FUNC_BYTES   = 4;
    localparam int ID_BASE      = REG_BASE + REG_BYTES;
    localparam int ID_BYTES     = 8;
    localparam int STORE_BYTES  = ID_BASE;

    localparam logic [7:0] CODE_A    = 8'hAA;
    localparam logic [7:0] CODE_B    = 8'h55;
    localparam logic [7:0] HIDDEN_RD = 8'hFF;

    typedef enum logic [2:0] {
        RG_DATA, RG_SECRET, RG_FUNC, RG_USER, RG_MAKER, RG_IDENT, RG_NONE
    } region_e;

    typedef struct packed {
        logic secret_lock;
        logic all_lock;
        logic clear_only;
        logic page0_lock;
    } guard_t;

    function automatic logic is_code(input logic [7:0] b);
        return (b == CODE_A) || (b == CODE_B);
    endfunction

    function automatic region_e region_of(input logic [7:0] a);
        if (a < 8'(SECRET_BASE))              return RG_DATA;
        if (a < 8'(REG_BASE))                 return RG_SECRET;
        if (a < 8'(REG_BASE + FUNC_BYTES))    return RG_FUNC;
        if (a < 8'(REG_BASE + FUNC_BYTES + 2)) return RG_USER;
        if (a < 8'(ID_BASE))                  return RG_MAKER;
        if (a < 8'(ID_BASE + ID_BYTES))       return RG_IDENT;
        return RG_NONE;
    endfunction

endpackage

// File: rtl/wg_lock_decode.sv
module wg_lock_decode
    import wg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [FUNC_BYTES*8-1:0]   func_bytes,
    output guard_t                    grd
);

    always_comb begin
        grd.secret_lock = is_code(func_bytes[7:0]);
        grd.all_lock    = is_code(func_bytes[15:8]);
        grd.clear_only  = is_code(func_bytes[23:16]);
        grd.page0_lock  = is_code(func_bytes[31:24]);
    end

    // Once a function is active only reset can clear it.
    assert_all_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(grd.all_lock)) |-> grd.all_lock);
    assert_secret_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(grd.secret_lock)) |-> grd.secret_lock);

endmodule

// File: rtl/wg_lane.sv
module wg_lane
    import wg_pkg::*;
(
    input  logic [7:0] lane_addr,
    input  logic [7:0] old_b,
    input  logic [7:0] new_b,
    input  guard_t     grd,
    input  logic       maker_lock,
    input  logic       go,
    output logic       en,
    output logic [7:0] val
);

    logic [7:0] page;
    assign page = lane_addr >> PAGE_SHIFT;

    always_comb begin
        en  = 1'b0;
        val = 8'h00;
        unique case (region_of(lane_addr))
            RG_DATA: begin
                if (!grd.all_lock && !(grd.page0_lock && page == 8'd0)) begin
                    en  = 1'b1;
                    val = (grd.clear_only && page == 8'd1) ? (old_b & new_b) : new_b;
                end
            end
            RG_SECRET: begin
                en  = !grd.secret_lock;
                val = new_b;
            end
            RG_FUNC: begin
                en  = !is_code(old_b);
                val = new_b;
            end
            RG_USER: begin
                en  = 1'b1;
                val = new_b;
            end
            RG_MAKER: begin
                en  = !maker_lock;
                val = new_b;
            end
            default: ;
        endcase
        if (!go || !en) begin
            en  = 1'b0;
            val = 8'h00;
        end
    end

endmodule

// File: rtl/wg_store.sv
module wg_store
    import wg_pkg::*;
#(
    parameter int         BYTES  = STORE_BYTES,
    parameter logic [7:0] ERASED = 8'hFF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [7:0]               base,
    input  logic [LANES-1:0]         lane_en,
    input  logic [LANES*8-1:0]       lane_val,
    output logic [LANES*8-1:0]       old_bytes,
    input  logic [7:0]               rd_addr,
    output logic [7:0]               rd_byte,
    output logic [FUNC_BYTES*8-1:0]  func_bytes,
    output logic [SECRET_BYTES*8-1:0] secret
);

    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < BYTES; k++) mem[k] <= ERASED;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_en[i] && (base + 8'(i)) < 8'(BYTES))
                    mem[base + 8'(i)] <= lane_val[i*8 +: 8];
            end
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_old
        logic [7:0] idx;
        assign idx = base + 8'(i);
        assign old_bytes[i*8 +: 8] = (idx < 8'(BYTES)) ? mem[idx] : ERASED;
    end

    for (genvar i = 0; i < FUNC_BYTES; i++) begin : g_func
        assign func_bytes[i*8 +: 8] = mem[REG_BASE + i];
    end

    for (genvar i = 0; i < SECRET_BYTES; i++) begin : g_sec
        assign secret[i*8 +: 8] = mem[SECRET_BASE + i];
    end

    assign rd_byte = (rd_addr < 8'(BYTES)) ? mem[rd_addr] : ERASED;

endmodule

// File: rtl/wg_guard.sv
module wg_guard
    import wg_pkg::*;
#(
    parameter logic [7:0] ERASED = 8'hFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmt_valid,
    input  logic [7:0]  cmt_addr,
    input  logic [63:0] cmt_data,
    input  logic [7:0]  factory_tag,
    input  logic [15:0] maker_id,
    input  logic [63:0] dev_id,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        wr_valid,
    output logic [7:0]  wr_en,
    output logic [63:0] wr_data,
    output logic [63:0] secret_key
);

    localparam logic [7:0] ALIGN_MASK = ~8'(LANES - 1);

    logic [7:0]              base;
    logic                    maker_lock;
    guard_t                  grd;
    logic [LANES-1:0]        lane_en;
    logic [LANES*8-1:0]      lane_val;
    logic [LANES*8-1:0]      old_bytes;
    logic [7:0]              store_rd;
    logic [FUNC_BYTES*8-1:0] func_bytes;

    assign base       = cmt_addr & ALIGN_MASK;
    assign maker_lock = (factory_tag == CODE_A);

    wg_store #(.ERASED(ERASED)) u_store (
        .clk        (clk),
        .rst        (rst),
        .base       (base),
        .lane_en    (lane_en),
        .lane_val   (lane_val),
        .old_bytes  (old_bytes),
        .rd_addr    (rd_addr),
        .rd_byte    (store_rd),
        .func_bytes (func_bytes),
        .secret     (secret_key)
    );

    wg_lock_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .func_bytes (func_bytes),
        .grd        (grd)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        wg_lane u_lane (
            .lane_addr  (base + 8'(i)),
            .old_b      (old_bytes[i*8 +: 8]),
            .new_b      (cmt_data[i*8 +: 8]),
            .grd        (grd),
            .maker_lock (maker_lock),
            .go         (cmt_valid),
            .en         (lane_en[i]),
            .val        (lane_val[i*8 +: 8])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_en    <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= cmt_valid;
            wr_en    <= lane_en;
            wr_data  <= lane_val;
        end
    end

    always_comb begin
        unique case (region_of(rd_addr))
            RG_SECRET: rd_data = HIDDEN_RD;
            RG_IDENT:  rd_data = dev_id[{rd_addr[2:0], 3'b000} +: 8];
            RG_MAKER:  rd_data = maker_lock ? maker_id[{rd_addr[0], 3'b000} +: 8] : store_rd;
            default:   rd_data = store_rd;
        endcase
    end

    assert_ident_ro_R8: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && cmt_addr >= 8'(ID_BASE)) |=> (wr_en == '0));
    assert_all_lock_R3: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && grd.all_lock && cmt_addr < 8'(SECRET_BASE)) |=> (wr_en == '0));
    assert_secret_lock_R6: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && grd.secret_lock && region_of(cmt_addr) == RG_SECRET) |=> (wr_en == '0));
    assert_clear_only_R5: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && grd.clear_only && !grd.all_lock && (cmt_addr >> PAGE_SHIFT) == 8'd1)
        |=> ((wr_data & ~$past(old_bytes)) == '0));
    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
        cmt_valid |=> wr_valid);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !cmt_valid |=> (wr_en == '0 && wr_data == '0));

endmodule

// File: tb/wg_guard_tb.sv
module wg_guard_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmt_valid;
    logic [7:0]  cmt_addr;
    logic [63:0] cmt_data;
    logic [7:0]  factory_tag;
    logic [15:0] maker_id;
    logic [63:0] dev_id;
    logic [7:0]  rd_addr;
    logic [7:0]  rd_data;
    logic        wr_valid;
    logic [7:0]  wr_en;
    logic [63:0] wr_data;
    logic [63:0] secret_key;

    always #(CLK_PERIOD/2) clk = ~clk;

    wg_guard u_dut (
        .clk(clk), .rst(rst), .cmt_valid(cmt_valid), .cmt_addr(cmt_addr),
        .cmt_data(cmt_data), .factory_tag(factory_tag), .maker_id(maker_id),
        .dev_id(dev_id), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_en(wr_en), .wr_data(wr_data),
        .secret_key(secret_key)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag;

    logic [7:0]  ref_mem [144];
    logic        exp_valid;
    logic [7:0]  exp_en;
    logic [63:0] exp_data;

    function automatic bit code(input logic [7:0] b);
        return b == 8'hAA || b == 8'h55;
    endfunction

    function automatic logic [7:0] ref_read(input int a);
        if (a >= 'h80 && a < 'h88) return 8'hFF;
        if (a >= 'h90 && a < 'h98) return dev_id[8*(a-'h90) +: 8];
        if ((a == 'h8E || a == 'h8F) && factory_tag == 8'hAA) return maker_id[8*(a-'h8E) +: 8];
        if (a < 'h90) return ref_mem[a];
        return 8'hFF;
    endfunction

    task automatic model_commit();
        int base = int'(cmt_addr) & 'hF8;
        logic [7:0] v [8];
        exp_valid = 1'b1;
        exp_en    = '0;
        exp_data  = '0;
        for (int i = 0; i < 8; i++) begin
            int a = base + i;
            logic [7:0] nb = cmt_data[8*i +: 8];
            bit ok = 0;
            v[i] = nb;
            if (a < 'h80) begin
                ok = !code(ref_mem['h89]) && !(code(ref_mem['h8B]) && a < 'h20);
                if (code(ref_mem['h8A]) && a >= 'h20 && a < 'h40) v[i] = ref_mem[a] & nb;
            end else if (a < 'h88) ok = !code(ref_mem['h88]);
            else if (a < 'h8C) ok = !code(ref_mem[a]);
            else if (a < 'h8E) ok = 1;
            else if (a < 'h90) ok = (factory_tag != 8'hAA);
            exp_en[i] = ok;
            if (ok) exp_data[8*i +: 8] = v[i];
        end
        for (int i = 0; i < 8; i++) if (exp_en[i]) ref_mem[base + i] = v[i];
    endtask

    task automatic check(input string what, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        if (rst) begin
            for (int k = 0; k < 144; k++) ref_mem[k] = 8'hFF;
            exp_valid = 0; exp_en = '0; exp_data = '0;
        end else if (cmt_valid) model_commit();
        else begin
            exp_valid = 0; exp_en = '0; exp_data = '0;
        end
        @(posedge clk);
        @(negedge clk);
        check("write port", {55'd0, wr_valid, wr_en, wr_data}, {55'd0, exp_valid, exp_en, exp_data});
        check("read port", {120'd0, rd_data}, {120'd0, ref_read(int'(rd_addr))});
        begin
            logic [63:0] k;
            for (int i = 0; i < 8; i++) k[8*i +: 8] = ref_mem['h80 + i];
            check("secret port", {64'd0, secret_key}, {64'd0, k});
        end
    endtask

    task automatic rd(input logic [7:0] a);
        rd_addr = a;
        step();
    endtask

    task automatic commit(input logic [7:0] a, input logic [63:0] d, input logic [7:0] ra);
        cmt_valid = 1; cmt_addr = a; cmt_data = d; rd_addr = ra;
        step();
        cmt_valid = 0;
        step();
    endtask

    task automatic commit_reg(input int idx, input logic [7:0] val, input logic [7:0] ra);
        logic [63:0] d;
        for (int k = 0; k < 8; k++) d[8*k +: 8] = ref_mem['h88 + k];
        d[8*idx +: 8] = val;
        commit(8'h88, d, ra);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; cmt_valid = 0; cmt_addr = 0; cmt_data = 0; rd_addr = 0;
        factory_tag = 8'h55; maker_id = 16'hC3A5; dev_id = 64'h5A44_3322_1100_EE33;
        tag = "R1 reset";
        @(negedge clk);
        repeat (3) step();
        rst = 0;
        rd(8'h00); rd(8'h8A); rd(8'h88); rd(8'h8C);

        tag = "R9 aligned commit";
        commit(8'h45, 64'h0807_0605_0403_0201, 8'h41);
        rd(8'h47);
        commit(8'h78, 64'h1111_2222_3333_4444, 8'h7F);

        tag = "R6 open secret";
        commit(8'h83, 64'h8877_6655_4433_2211, 8'h80);
        rd(8'h87);

        tag = "R5 clear-only page 1";
        commit(8'h20, 64'hF0F0_F0F0_AAAA_FFFF, 8'h20);
        commit_reg(2, 8'hAA, 8'h8A);
        commit(8'h22, 64'h0F0F_FF00_5555_00FF, 8'h21);
        for (int k = 0; k < 8; k++) rd(8'h20 + 8'(k));
        commit(8'h3F, 64'hFFFF_FFFF_FFFF_FFFF, 8'h3C);
        commit(8'h60, 64'h0123_4567_89AB_CDEF, 8'h63);
        commit(8'h00, 64'h1357_9BDF_0246_8ACE, 8'h02);

        tag = "R2 function byte lock";
        commit_reg(2, 8'h00, 8'h8A);
        commit_reg(0, 8'h12, 8'h88);
        commit_reg(0, 8'h34, 8'h88);
        commit_reg(3, 8'h7E, 8'h8B);

        tag = "R4 page 0 lock";
        commit_reg(3, 8'h55, 8'h8B);
        commit(8'h00, 64'h0, 8'h01);
        commit(8'h28, 64'h0000_0000_FFFF_0000, 8'h29);
        commit(8'h40, 64'hDEAD_BEEF_CAFE_F00D, 8'h44);

        tag = "R6 secret lock";
        commit_reg(0, 8'hAA, 8'h88);
        commit(8'h80, 64'h0, 8'h84);
        rd(8'h81);

        tag = "R7 maker bytes";
        commit_reg(6, 8'h5A, 8'h8E);
        commit_reg(7, 8'h6B, 8'h8F);
        factory_tag = 8'hAA;
        rd(8'h8E); rd(8'h8F);
        commit_reg(7, 8'h00, 8'h8F);
        commit_reg(4, 8'h99, 8'h8C);
        commit_reg(5, 8'hAA, 8'h8D);
        commit_reg(5, 8'h01, 8'h8D);
        factory_tag = 8'h55;
        rd(8'h8F); rd(8'h8E);

        tag = "R8 identity window";
        for (int k = 0; k < 8; k++) rd(8'h90 + 8'(k));
        commit(8'h90, 64'h0, 8'h90);
        commit(8'h98, 64'h0, 8'h98);
        commit(8'hF8, 64'h0, 8'hFF);
        rd(8'hA0);

        tag = "R3 all-page lock";
        commit_reg(1, 8'h55, 8'h89);
        commit(8'h00, 64'h0, 8'h00);
        commit(8'h20, 64'h0, 8'h20);
        commit(8'h60, 64'h0, 8'h60);
        commit_reg(1, 8'h00, 8'h89);
        rd(8'h41);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule